// File: doc/BRIEF.md
# Interrupt Cache Freeze Controller

This block owns a cache control register that software reads and writes through a simple one-cycle port. Two 2-bit fields in it hold the state of an instruction cache and a data cache, and two further bits select, per cache, whether that cache should be frozen when an interrupt is taken. The caches themselves sit elsewhere; they only watch the state fields.

When the processor acknowledges an interrupt, the block passes the acknowledge with its interrupt number on to the interrupt controller one cycle later. In the same clock edge it checks each cache on its own. A cache whose freeze bit is set and whose state is enabled is moved to frozen. A handler then runs without evicting the lines that the interrupted code relied on. Every other bit of the register stays as software left it.

If software writes the register in the same cycle as an acknowledge, the written value is taken first and the freeze check is made on that value.

Top module: `cache_freeze_ctrl`

## Requirements
- R1: After reset the register reads as all zeros (both caches disabled, both freeze bits clear) and the forwarded acknowledge output is low.
- R2: A write with `wrEn` high stores all REG_W bits of `wrData`, and `rdData` shows them from the next cycle on.
- R3: Bits [1:0] hold the instruction cache state, coded disabled 00, frozen 01, enabled 11. Bit 4 is its freeze bit. On an acknowledge with bit 4 set and bits [1:0] at 11, bits [1:0] become 01 in the next cycle.
- R4: Bits [3:2] hold the data cache state, with the same coding. Bit 5 is its freeze bit. On an acknowledge with bit 5 set and bits [3:2] at 11, bits [3:2] become 01 in the next cycle.
- R5: A cache whose freeze bit is clear keeps its state field unchanged across an acknowledge.
- R6: A cache whose state is 00, 01 or 10 keeps that value across an acknowledge even when its freeze bit is set.
- R7: An acknowledge never changes bits [REG_W-1:4] of the register.
- R8: Each cycle with `ackValid` high produces exactly one cycle of `fwdValid` in the next cycle, with `fwdId` equal to the acknowledged `ackId`. With no acknowledge, `fwdValid` is low.
- R9: When a write and an acknowledge fall in the same cycle, the register takes the written value with the freeze rules applied to that value, not to the old contents.
- R10: The two caches are decided independently: one can freeze while the other, with its freeze bit clear, stays enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Software write strobe |
| wrData | input | REG_W | Software write data |
| rdData | output | REG_W | Current register contents |
| ackValid | input | 1 | Interrupt acknowledge from the processor |
| ackId | input | ID_W | Number of the acknowledged interrupt |
| fwdValid | output | 1 | Acknowledge forwarded to the interrupt controller |
| fwdId | output | ID_W | Interrupt number forwarded |

## Verification
The freeze rule is driven with every pairing of freeze bit and state value that matters: only the freeze bit set, only the state enabled, both, and the states frozen and reserved with the freeze bit set. These separate a design that keys on the bit from one that keys on the state. Register values with both caches enabled but only one freeze bit set show whether the fields are decided separately. Values with busy upper bits show that the freeze touches only its own two bits. A write coinciding with an acknowledge, once onto a freezable value and once over an old freezable value, shows which value the check reads.

// File: rtl/cfz_pkg.sv
package cfz_pkg;
  localparam int NUM_CACHES  = 2;
  localparam int STATE_W     = 2;
  localparam int FE_BASE     = NUM_CACHES * STATE_W;
  localparam int CTRL_W      = FE_BASE + NUM_CACHES;

  typedef enum logic [STATE_W-1:0] {
    CS_OFF    = 2'b00,
    CS_FROZEN = 2'b01,
    CS_ON     = 2'b11
  } cacheState_t;

  typedef struct packed {
    logic                  load;
    logic [NUM_CACHES-1:0] freeze;
    logic                  fwd;
  } strobe_t;
endpackage

// File: rtl/cfz_control.sv
module cfz_control
  import cfz_pkg::*;
(
  input  logic              wrEn,
  input  logic [CTRL_W-1:0] wrLow,
  input  logic [CTRL_W-1:0] regLow,
  input  logic              ackValid,
  output strobe_t           strobes
);
  logic [CTRL_W-1:0] effLow;

  // Freeze decision is made on the value the register would hold after a write.
  assign effLow = wrEn ? wrLow : regLow;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CACHES; gi++) begin : g_cache
      logic [STATE_W-1:0] curState;
      assign curState = effLow[gi*STATE_W +: STATE_W];
      assign strobes.freeze[gi] = ackValid && effLow[FE_BASE+gi] &&
                                  (curState == CS_ON);
    end
  endgenerate

  assign strobes.load = wrEn;
  assign strobes.fwd  = ackValid;
endmodule

// File: rtl/cfz_datapath.sv
module cfz_datapath
  import cfz_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int ID_W  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobes,
  input  logic [REG_W-1:0] wrData,
  input  logic [ID_W-1:0]  ackId,
  output logic [REG_W-1:0] ctrlQ,
  output logic             fwdValid,
  output logic [ID_W-1:0]  fwdId
);
  logic [REG_W-1:0] loaded;
  logic [REG_W-1:0] ctrlD;

  assign loaded = strobes.load ? wrData : ctrlQ;

  always_comb begin
    ctrlD = loaded;
    for (int i = 0; i < NUM_CACHES; i++) begin
      if (strobes.freeze[i]) ctrlD[i*STATE_W +: STATE_W] = CS_FROZEN;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ    <= '0;
      fwdValid <= 1'b0;
      fwdId    <= '0;
    end else begin
      ctrlQ    <= ctrlD;
      fwdValid <= strobes.fwd;
      if (strobes.fwd) fwdId <= ackId;
    end
  end
endmodule

// File: rtl/cache_freeze_ctrl.sv
module cache_freeze_ctrl
  import cfz_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int ID_W  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  input  logic             ackValid,
  input  logic [ID_W-1:0]  ackId,
  output logic             fwdValid,
  output logic [ID_W-1:0]  fwdId
);
  strobe_t          strobes;
  logic [REG_W-1:0] ctrlQ;

  cfz_control u_ctrl (
    .wrEn     (wrEn),
    .wrLow    (wrData[CTRL_W-1:0]),
    .regLow   (ctrlQ[CTRL_W-1:0]),
    .ackValid (ackValid),
    .strobes  (strobes)
  );

  cfz_datapath #(.REG_W(REG_W), .ID_W(ID_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .wrData   (wrData),
    .ackId    (ackId),
    .ctrlQ    (ctrlQ),
    .fwdValid (fwdValid),
    .fwdId    (fwdId)
  );

  assign rdData = ctrlQ;
endmodule

// File: rtl/cfz_checker.sv
module cfz_checker #(
  parameter int REG_W = 32,
  parameter int ID_W  = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic             ackValid,
  input logic [ID_W-1:0]  ackId,
  input logic [REG_W-1:0] rdData,
  input logic             fwdValid,
  input logic [ID_W-1:0]  fwdId
);
  a_r3_ifreeze: assert property (@(posedge clk) disable iff (!rstN)
    (ackValid && !wrEn && rdData[4] && rdData[1:0] == 2'b11) |=> rdData[1:0] == 2'b01);

  a_r4_dfreeze: assert property (@(posedge clk) disable iff (!rstN)
    (ackValid && !wrEn && rdData[5] && rdData[3:2] == 2'b11) |=> rdData[3:2] == 2'b01);

  a_r5_iheld: assert property (@(posedge clk) disable iff (!rstN)
    (ackValid && !wrEn && !rdData[4]) |=> $stable(rdData[1:0]));

  a_r6_dheld: assert property (@(posedge clk) disable iff (!rstN)
    (ackValid && !wrEn && rdData[3:2] != 2'b11) |=> $stable(rdData[3:2]));

  a_r7_upper: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn) |=> $stable(rdData[REG_W-1:4]));

  a_r8_fwd: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |=> (fwdValid && fwdId == $past(ackId)));

  a_r8_nofwd: assert property (@(posedge clk) disable iff (!rstN)
    !ackValid |=> !fwdValid);
endmodule

bind cache_freeze_ctrl cfz_checker #(.REG_W(REG_W), .ID_W(ID_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .ackValid (ackValid),
  .ackId    (ackId),
  .rdData   (rdData),
  .fwdValid (fwdValid),
  .fwdId    (fwdId)
);

// File: tb/cache_freeze_ctrl_tb.sv
module cache_freeze_ctrl_tb;
  localparam int REG_W = 32;
  localparam int ID_W  = 4;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             wrEn = 1'b0;
  logic [REG_W-1:0] wrData = '0;
  logic [REG_W-1:0] rdData;
  logic             ackValid = 1'b0;
  logic [ID_W-1:0]  ackId = '0;
  logic             fwdValid;
  logic [ID_W-1:0]  fwdId;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cache_freeze_ctrl #(.REG_W(REG_W), .ID_W(ID_W)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .ackValid(ackValid), .ackId(ackId), .fwdValid(fwdValid), .fwdId(fwdId)
  );

  task automatic check(string tag, logic [REG_W-1:0] act, logic [REG_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one cycle of inputs, then sample just after the edge.
  task automatic step(bit we, logic [REG_W-1:0] wd, bit ack, logic [ID_W-1:0] id);
    @(negedge clk);
    wrEn = we; wrData = wd; ackValid = ack; ackId = id;
    @(posedge clk);
    #1;
    @(negedge clk);
    wrEn = 1'b0; ackValid = 1'b0;
  endtask

  task automatic writeReg(logic [REG_W-1:0] v);
    step(1'b1, v, 1'b0, '0);
  endtask

  task automatic ackOnly(logic [ID_W-1:0] id);
    step(1'b0, '0, 1'b1, id);
  endtask

  task automatic testReset();
    check("R1 reg", rdData, '0);
    check("R1 fwd", {31'b0, fwdValid}, 32'd0);
  endtask

  task automatic testWrite();
    writeReg(32'hA5C3_5A0C);
    check("R2 readback", rdData, 32'hA5C3_5A0C);
    writeReg(32'h0000_0000);
    check("R2 clear", rdData, 32'h0);
  endtask

  task automatic testIFreeze();
    writeReg(32'h13);
    ackOnly(4'h7);
    check("R3 ifreeze", rdData, 32'h11);
    check("R8 fwdValid", {31'b0, fwdValid}, 32'd1);
    check("R8 fwdId", {28'b0, fwdId}, 32'h7);
    @(posedge clk); #1;
    check("R8 single", {31'b0, fwdValid}, 32'd0);
  endtask

  task automatic testDFreeze();
    writeReg(32'h2C);
    ackOnly(4'hC);
    check("R4 dfreeze", rdData, 32'h24);
    check("R8 fwdId", {28'b0, fwdId}, 32'hC);
  endtask

  task automatic testNoEnable();
    writeReg(32'h0F);
    ackOnly(4'h1);
    check("R5 noenable", rdData, 32'h0F);
  endtask

  task automatic testStates();
    writeReg(32'h36);
    ackOnly(4'h2);
    check("R6 states 10/01", rdData, 32'h36);
    writeReg(32'h30);
    ackOnly(4'h3);
    check("R6 states off", rdData, 32'h30);
  endtask

  task automatic testUpper();
    writeReg(32'hDEAD_BE33);
    ackOnly(4'h9);
    check("R7 upper", rdData, 32'hDEAD_BE31);
  endtask

  task automatic testIndependent();
    writeReg(32'h3F);
    ackOnly(4'h4);
    check("R10 both", rdData, 32'h35);
    writeReg(32'h1F);
    ackOnly(4'h5);
    check("R10 only I", rdData, 32'h1D);
    writeReg(32'h2F);
    ackOnly(4'h6);
    check("R10 only D", rdData, 32'h27);
  endtask

  task automatic testCollide();
    writeReg(32'h0);
    step(1'b1, 32'h13, 1'b1, 4'hA);
    check("R9 write then freeze", rdData, 32'h11);
    writeReg(32'h13);
    step(1'b1, 32'h03, 1'b1, 4'hB);
    check("R9 old value ignored", rdData, 32'h03);
    check("R8 fwdId collide", {28'b0, fwdId}, 32'hB);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    testReset();
    @(negedge clk);
    rstN = 1'b1;
    testWrite();
    testIFreeze();
    testDFreeze();
    testNoEnable();
    testStates();
    testUpper();
    testIndependent();
    testCollide();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule